// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block is a sequential arithmetic unit that sits beside an integer pipeline. It takes one operation per start pulse. The operation is a signed or unsigned multiply, or a signed or unsigned divide, of two 32-bit operands. It works out one bit of the result per clock cycle. While it works, it raises `busy`, and the pipeline must not read the results until `busy` drops.

All results go to a dedicated pair of 32-bit result registers, HI and LO, which are read back through two plain output ports. A multiply leaves the upper half of its 64-bit product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI.

Both operand paths convert signed values to magnitudes, run an unsigned iteration, and fix the signs when the result is written. Division by zero takes the same number of cycles as any other operation and writes a fixed result.

Top module: `muldiv_top`

## Requirements
- R1: With `opSel` = 2'b00 (signed multiply), HI:LO receives the 64-bit two's-complement product of `opA` and `opB`, with the upper 32 bits in HI and the lower 32 bits in LO.
- R2: With `opSel` = 2'b01 (unsigned multiply), HI:LO receives the 64-bit unsigned product, split the same way as in R1.
- R3: With `opSel` = 2'b11 (unsigned divide) and a nonzero divisor, LO receives `opA / opB` and HI receives `opA % opB`, both taken as unsigned numbers.
- R4: With `opSel` = 2'b10 (signed divide) and a nonzero divisor, the quotient in LO is truncated toward zero, and the remainder in HI is either zero or has the sign of the dividend.
- R5: A signed divide of 32'h8000_0000 by 32'hFFFF_FFFF writes LO = 32'h8000_0000 and HI = 0, with no other effect.
- R6: A divide of either kind by zero writes LO = 32'hFFFF_FFFF and HI = the dividend `opA` unchanged. The unit then returns to idle after the normal busy window.
- R7: A start is accepted on a rising edge where `startValid` is high and `busy` is low. `busy` is high from the next cycle on, stays high for exactly 32 cycles, and HI/LO hold the new result in the first cycle in which `busy` is low again.
- R8: A `startValid` pulse while `busy` is high is ignored. Neither the running operation's result nor its busy window changes.
- R9: After reset, HI and LO read zero. HI and LO change only when an operation completes, so while `busy` is high they return the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request, accepted only while idle |
| opSel | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| hiOut | output | 32 | HI register: product upper half or remainder |
| loOut | output | 32 | LO register: product lower half or quotient |

## Verification
Any error in an iteration step, or in the accumulator or divisor registers, stays hidden until completion. It then appears in HI/LO in the first idle cycle, exactly 32 cycles after the start. Operand pairs are therefore chosen to exercise every sign combination, carries across the 32-bit boundary, and zero divisors.

An off-by-one in the iteration counter shows as a busy window of the wrong length and usually as a result shifted by one bit. A control state that never returns to idle shows as `busy` that never falls.

A datapath that writes HI/LO outside completion shows as HI/LO changing in the middle of the busy window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdOp_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadEn;    // capture operands, start iterating
    logic stepEn;    // perform one iteration
    logic finishEn;  // perform the last iteration and write HI/LO
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  output mdStrobe_t strobe,
  output logic      busy
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic             running;
  logic [CNT_W-1:0] stepCount;
  logic             lastStep;

  assign lastStep = (stepCount == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      stepCount <= '0;
    end else if (!running) begin
      if (startValid) begin
        running   <= 1'b1;
        stepCount <= '0;
      end
    end else begin
      stepCount <= stepCount + 1'b1;
      if (lastStep) running <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadEn   = !running && startValid;
    strobe.stepEn   = running && !lastStep;
    strobe.finishEn = running && lastStep;
  end

  assign busy = running;

  // independent count of busy cycles, used only by the checks below
  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)        busyRun <= '0;
    else if (running) busyRun <= busyRun + 1'b1;
    else              busyRun <= '0;
  end

  assert_busy_rises_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid) |=> busy);

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == (CNT_W+1)'(WIDTH)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyRun < (CNT_W+1)'(WIDTH - 1)) |=> busy);

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadEn, strobe.stepEn, strobe.finishEn}));

endmodule

// File: rtl/muldiv_dpath.sv
module muldiv_dpath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strobe,
  input  mdOp_t            opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  // operation state captured at load
  logic             isDiv;
  logic             negMain;     // negate product or quotient
  logic             negRem;      // negate remainder
  logic             divZero;
  logic             dividendNeg;
  logic             signedDiv;
  logic [WIDTH-1:0] operandM;    // multiplicand or divisor magnitude

  // shared accumulator: accHi is product-high or partial remainder,
  // accLo is multiplier bits or dividend/quotient bits
  logic [WIDTH:0]   accHi;
  logic [WIDTH-1:0] accLo;

  logic [WIDTH-1:0] hiReg;
  logic [WIDTH-1:0] loReg;

  // load-time magnitude conversion
  logic             loadSigned;
  logic             aNeg;
  logic             bNeg;
  logic [WIDTH-1:0] magA;
  logic [WIDTH-1:0] magB;

  always_comb begin
    loadSigned = !opSel[0];
    aNeg = loadSigned && opA[WIDTH-1];
    bNeg = loadSigned && opB[WIDTH-1];
    magA = aNeg ? (~opA + 1'b1) : opA;
    magB = bNeg ? (~opB + 1'b1) : opB;
  end

  // one multiply iteration: conditional add, then shift right
  logic [WIDTH:0]   mulSum;
  logic [WIDTH:0]   mulNextHi;
  logic [WIDTH-1:0] mulNextLo;

  always_comb begin
    mulSum    = accHi + (accLo[0] ? {1'b0, operandM} : '0);
    mulNextHi = {1'b0, mulSum[WIDTH:1]};
    mulNextLo = {mulSum[0], accLo[WIDTH-1:1]};
  end

  // one restoring divide iteration: shift left, trial subtract
  logic [WIDTH:0]   divShift;
  logic [WIDTH:0]   divDiff;
  logic             divFits;
  logic [WIDTH:0]   divNextHi;
  logic [WIDTH-1:0] divNextLo;

  always_comb begin
    divShift  = {accHi[WIDTH-1:0], accLo[WIDTH-1]};
    divDiff   = divShift - {1'b0, operandM};
    divFits   = !divDiff[WIDTH];
    divNextHi = divFits ? divDiff : divShift;
    divNextLo = {accLo[WIDTH-2:0], divFits};
  end

  logic [WIDTH:0]   nextHi;
  logic [WIDTH-1:0] nextLo;

  assign nextHi = isDiv ? divNextHi : mulNextHi;
  assign nextLo = isDiv ? divNextLo : mulNextLo;

  // final sign correction
  logic [2*WIDTH-1:0] prodRaw;
  logic [2*WIDTH-1:0] prodFix;
  logic [WIDTH-1:0]   quoFix;
  logic [WIDTH-1:0]   remFix;
  logic [WIDTH-1:0]   finalHi;
  logic [WIDTH-1:0]   finalLo;

  always_comb begin
    prodRaw = {nextHi[WIDTH-1:0], nextLo};
    prodFix = negMain ? (~prodRaw + 1'b1) : prodRaw;
    quoFix  = divZero ? '1 : (negMain ? (~nextLo + 1'b1) : nextLo);
    remFix  = negRem ? (~nextHi[WIDTH-1:0] + 1'b1) : nextHi[WIDTH-1:0];
    finalHi = isDiv ? remFix : prodFix[2*WIDTH-1:WIDTH];
    finalLo = isDiv ? quoFix : prodFix[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isDiv       <= 1'b0;
      negMain     <= 1'b0;
      negRem      <= 1'b0;
      divZero     <= 1'b0;
      dividendNeg <= 1'b0;
      signedDiv   <= 1'b0;
      operandM    <= '0;
      accHi       <= '0;
      accLo       <= '0;
      hiReg       <= '0;
      loReg       <= '0;
    end else begin
      if (strobe.loadEn) begin
        isDiv       <= opSel[1];
        negMain     <= aNeg ^ bNeg;
        negRem      <= opSel[1] && aNeg;
        divZero     <= opSel[1] && (opB == '0);
        dividendNeg <= opA[WIDTH-1];
        signedDiv   <= opSel[1] && loadSigned;
        operandM    <= magB;
        accHi       <= '0;
        accLo       <= magA;
      end else if (strobe.stepEn) begin
        accHi <= nextHi;
        accLo <= nextLo;
      end
      if (strobe.finishEn) begin
        accHi <= nextHi;
        accLo <= nextLo;
        hiReg <= finalHi;
        loReg <= finalLo;
      end
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  assert_hilo_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finishEn |=> ($stable(hiReg) && $stable(loReg)));

  assert_divzero_quotient_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishEn && isDiv && divZero) |=> (loReg == '1));

  assert_rem_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishEn && signedDiv && !divZero) |=>
      (hiReg == '0 || hiReg[WIDTH-1] == dividendNeg));

  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishEn && isDiv && !divZero && !negRem) |=> (hiReg < operandM));

endmodule

// File: rtl/muldiv_top.sv
module muldiv_top
  import muldiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [1:0]  opSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        busy,
  output logic [31:0] hiOut,
  output logic [31:0] loOut
);

  localparam int WIDTH = 32;

  mdStrobe_t strobe;

  muldiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .strobe     (strobe),
    .busy       (busy)
  );

  muldiv_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opSel  (mdOp_t'(opSel)),
    .opA    (opA),
    .opB    (opB),
    .hiOut  (hiOut),
    .loOut  (loOut)
  );

endmodule

// File: tb/muldiv_top_tb_top.sv
module muldiv_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy;
  logic [31:0] hiOut;
  logic [31:0] loOut;

  always #2 clk = ~clk;  // 250 MHz

  muldiv_top dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opSel(opSel),
    .opA(opA), .opB(opB), .busy(busy), .hiOut(hiOut), .loOut(loOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastHi = '0;
  logic [31:0] lastLo = '0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refResult(input logic [1:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin p = 64'(sa * sb); return p; end
      2'b01: begin p = {32'b0, a} * {32'b0, b}; return p; end
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  // driver: waits for idle, pushes the expected result, pulses start
  task automatic runOp(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string req,
                       input bit poke);
    while (busy) @(negedge clk);
    expQ.push_back(refResult(op, a, b));
    tagQ.push_back(req);
    opSel = op; opA = a; opB = b; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    repeat (10) @(negedge clk);
    check({hiOut, loOut} == {lastHi, lastLo}, "R9 hold during busy",
          {hiOut, loOut}, {lastHi, lastLo});
    if (poke) begin
      // R8: a start during busy with different operands must be ignored
      opSel = 2'b01; opA = 32'hDEAD_BEEF; opB = 32'h1234_5678; startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
    end
  endtask

  // monitor: counts the busy window and compares at completion
  int busyLen = 0;
  logic prevBusy = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyLen++;
      if (prevBusy && !busy) begin
        logic [63:0] e;
        string t;
        check(busyLen == 32, "R7 busy length", 64'(busyLen), 64'd32);
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected completion", {hiOut, loOut}, 64'd0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({hiOut, loOut} == e, t, {hiOut, loOut}, e);
          lastHi = e[63:32];
          lastLo = e[31:0];
        end
        busyLen = 0;
      end
      prevBusy <= busy;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({hiOut, loOut} == 64'd0, "R9 reset HI/LO", {hiOut, loOut}, 64'd0);
    check(busy == 1'b0, "R7 reset busy", 64'(busy), 64'd0);

    runOp(2'b00, 32'd7, 32'hFFFF_FFFD, "R1 signed mul pos*neg", 0);
    runOp(2'b00, 32'h8000_0000, 32'h8000_0000, "R1 signed mul min*min", 0);
    runOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 signed mul -1*-1", 1);
    runOp(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 unsigned mul max*max", 0);
    runOp(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R2 unsigned mul", 0);
    runOp(2'b11, 32'd100, 32'd7, "R3 unsigned div", 0);
    runOp(2'b11, 32'hFFFF_FFFF, 32'h8000_0001, "R3 unsigned div large", 1);
    runOp(2'b11, 32'd5, 32'd9, "R3 unsigned div small", 0);
    runOp(2'b10, 32'hFFFF_FF9C, 32'd7, "R4 signed div neg/pos", 0);
    runOp(2'b10, 32'd100, 32'hFFFF_FFF9, "R4 signed div pos/neg", 0);
    runOp(2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R4 signed div neg/neg", 0);
    runOp(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min div minus one", 0);
    runOp(2'b11, 32'h1357_9BDF, 32'd0, "R6 unsigned div by zero", 0);
    runOp(2'b10, 32'hF000_0001, 32'd0, "R6 signed div by zero", 1);
    runOp(2'b01, 32'd3, 32'd5, "R6 recovery after div by zero", 0);

    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R8 idle at end", 64'(busy), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired busy=%b", busy);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule